// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes queued in a small transmit FIFO into asynchronous serial frames. The character length, the parity scheme and the number of stop bits come from a mode word. The block reads that word once per frame, at the moment it loads a character. A baud generator outside the block supplies a one-cycle `bit_tick` pulse at the bit rate, and every bit on the line lasts from one tick to the next.

Software-facing logic controls the block through a command strobe and a command word. One pair of bits enables and disables the transmitter, and disable takes priority. Another pair starts and ends a break. A further bit is a one-shot soft reset that flushes the FIFO and returns the line to idle. The receive path, modem signals and test loopback belong to other blocks.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is one low start bit, then the data bits LSB first, then the parity bit if one is selected, then the high stop bits. Each bit appears on `txd` one clock after the `bit_tick` that begins it and holds until the next tick. `txd` changes only in a cycle that follows a tick or a command.
- R2: `mode_word[2:1]` selects the character length: 00 or 01 sends 8 data bits, 10 sends 7 and 11 sends 6. Unused upper data bits are not sent.
- R3: `mode_word[5:3]` selects the parity. 000 is even, so the data plus parity hold an even number of ones. 001 is odd. 010 always sends 0 and 011 always sends 1. Any value 1xx sends no parity bit.
- R4: `mode_word[7]`=1 sends two stop bits and 0 sends one.
- R5: A command with `cmd_word[1]` set empties the FIFO and aborts any frame. One clock later `txd` is high unless a break is active. A FIFO write in the same cycle is dropped.
- R6: A command with `cmd_word[7]` set drives `txd` low from the next clock, whatever the shifter is doing. `cmd_word[8]` releases the break. When both bits are set, the release wins.
- R7: The FIFO holds 16 characters and sends them in write order. `fifo_empty` and `fifo_full` report its state and are never both high.
- R8: A write while `fifo_full` is high is dropped and does not change the queued characters.
- R9: `cmd_word[4]` enables the transmitter and `cmd_word[5]` disables it. When both are set, disable wins. The transmitter is disabled after reset. While it is disabled, no new frame starts and queued characters wait.
- R10: The next character loads at the tick that ends the last stop bit, so frames run back to back with no idle bit. A mode change made during a frame applies only from the next frame.
- R11: After reset, `txd` is 1, `fifo_empty` is 1 and `fifo_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe into the FIFO |
| wr_data | input | 8 | Character to queue |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 9 | Command bits: 1 flush, 4 enable, 5 disable, 7 break on, 8 break off |
| mode_word | input | 8 | Frame format: [2:1] length, [5:3] parity, [7] stop count |
| txd | output | 1 | Serial line, idle high |
| fifo_empty | output | 1 | FIFO holds no character |
| fifo_full | output | 1 | FIFO holds 16 characters |

## Verification
Each line bit is due one clock after the tick that starts it. The bench therefore raises `bit_tick` for one cycle and samples `txd` at the next falling edge, after that single register update. Command effects (break, flush, enable) and the FIFO flags are also due one clock after their strobe, and the bench samples them at the falling edge that ends the strobe. The idle level after a frame is checked one tick after the last stop bit. That is the tick at which a queued character would otherwise have started.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       bit_tick,
  input  logic       cmd_valid,
  input  logic [8:0] cmd_word,
  input  logic [7:0] mode_word,
  output logic       txd,
  output logic       fifo_empty,
  output logic       fifo_full
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wp, rp;
  logic        tx_on, brk, busy, line;
  logic [10:0] frame, nxt;
  logic [3:0]  left, len, nb;
  logic        pe, pbit, pm;
  logic [7:0]  d;

  assign fifo_empty = (wp == rp);
  assign fifo_full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  wire flush = cmd_valid & cmd_word[1];
  wire push  = wr_en & ~fifo_full & ~flush;
  wire load  = bit_tick & tx_on & ~fifo_empty & ~flush & (~busy | (left == 4'd0));

  assign d = mem[rp[AW-1:0]];

  always_comb begin
    case (mode_word[2:1])
      2'b10:   len = 4'd7;
      2'b11:   len = 4'd6;
      default: len = 4'd8;
    endcase
    pm = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(len)) pm = pm ^ d[i];
    pe = ~mode_word[5];
    case (mode_word[4:3])
      2'b00:   pbit = pm;
      2'b01:   pbit = ~pm;
      2'b10:   pbit = 1'b0;
      default: pbit = 1'b1;
    endcase
    nxt = '1;
    for (int i = 0; i < 11; i++) begin
      if (i < int'(len)) nxt[i] = d[i];
      else if (i == int'(len) && pe) nxt[i] = pbit;
    end
    nb = len + {3'b000, pe} + (mode_word[7] ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      tx_on <= 1'b0;
      brk   <= 1'b0;
      busy  <= 1'b0;
      line  <= 1'b1;
      frame <= '1;
      left  <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (flush) begin
        rp   <= wp;
        busy <= 1'b0;
        line <= 1'b1;
        left <= '0;
      end else if (load) begin
        rp    <= rp + 1'b1;
        line  <= 1'b0;
        frame <= nxt;
        left  <= nb;
        busy  <= 1'b1;
      end else if (bit_tick && busy) begin
        if (left != 4'd0) begin
          line  <= frame[0];
          frame <= {1'b1, frame[10:1]};
          left  <= left - 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end
      if (cmd_valid) begin
        if (cmd_word[5])      tx_on <= 1'b0;
        else if (cmd_word[4]) tx_on <= 1'b1;
        if (cmd_word[8])      brk <= 1'b0;
        else if (cmd_word[7]) brk <= 1'b1;
      end
    end
  end

  assign txd = line & ~brk;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       bit_tick,
  input logic       cmd_valid,
  input logic [8:0] cmd_word,
  input logic [7:0] mode_word,
  input logic       txd,
  input logic       fifo_empty,
  input logic       fifo_full
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(fifo_full && fifo_empty)); // R7
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!bit_tick && !cmd_valid) |=> $stable(txd)); // R1
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_word[7] && !cmd_word[8]) |=> !txd); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_word[1]) |=> fifo_empty); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (fifo_full && wr_en && !bit_tick && !cmd_valid) |=> fifo_full); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (fifo_empty && wr_en && !cmd_valid) |=> !fifo_empty); // R7
endmodule

bind uart_frame_tx uart_frame_tx_chk chk (.*);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, wr_en = 1'b0, bit_tick = 1'b0, cmd_valid = 1'b0;
  logic [7:0] wr_data = '0, mode_word = 8'h20;
  logic [8:0] cmd_word = '0;
  logic       txd, fifo_empty, fifo_full;
  int n_run = 0, n_fail = 0;

  uart_frame_tx dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic cmd(input logic [8:0] w);
    @(negedge clk) begin cmd_valid = 1'b1; cmd_word = w; end
    @(negedge clk) begin cmd_valid = 1'b0; cmd_word = '0; end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic int flen(input logic [7:0] m);
    return (m[2:1] == 2'b10) ? 7 : (m[2:1] == 2'b11) ? 6 : 8;
  endfunction

  function automatic int fbits(input logic [7:0] m);
    return 1 + flen(m) + (m[5] ? 0 : 1) + (m[7] ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] m, input logic [7:0] d, input int k);
    int  n = flen(m);
    logic p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    if (k == 0) return 1'b0;
    if (k <= n) return d[k-1];
    if (!m[5] && k == n + 1)
      case (m[4:3])
        2'b00:   return p;
        2'b01:   return ~p;
        2'b10:   return 1'b0;
        default: return 1'b1;
      endcase
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [7:0] m, input logic [7:0] d, input string tag,
                           input bit chg, input logic [7:0] m2);
    int n = fbits(m);
    int got = 0, exp = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      got[k] = txd;
      exp[k] = exp_bit(m, d, k);
      if (k == 0 && chg) mode_word = m2;
    end
    chk(got == exp, tag, got, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && fifo_empty && !fifo_full, "R11", {txd, fifo_empty, fifo_full}, 3'b110);

    put(8'h5A);
    tick(); tick();
    chk(txd == 1'b1 && !fifo_empty, "R9 disabled after reset", {txd, fifo_empty}, 2'b10);
    cmd(9'h002);
    chk(fifo_empty, "R5 flush", fifo_empty, 1);

    cmd(9'h010);
    for (int lc = 0; lc < 4; lc++)
      for (int pr = 0; pr < 5; pr++)
        for (int st = 0; st < 2; st++) begin
          logic [7:0] m, b1, b2;
          m  = {st[0], 1'b0, pr[2:0], lc[1:0], 1'b0};
          b1 = 8'hA5 ^ 8'(lc * 53 + pr * 29 + st * 7);
          b2 = ~b1 ^ 8'(pr);
          mode_word = m;
          put(b1);
          put(b2);
          run_frame(m, b1, "R1 R2 R3 R4 frame", 1'b0, m);
          run_frame(m, b2, "R10 back-to-back R2 R3 R4", 1'b0, m);
          tick();
          chk(txd == 1'b1 && fifo_empty, "R10 idle after last stop", {txd, fifo_empty}, 2'b11);
        end

    mode_word = 8'h20;
    put(8'h3C);
    put(8'hC3);
    run_frame(8'h20, 8'h3C, "R10 mode held in frame", 1'b1, 8'h8C);
    run_frame(8'h8C, 8'hC3, "R10 mode applied next frame", 1'b0, 8'h8C);
    tick();
    mode_word = 8'h20;

    cmd(9'h020);
    for (int i = 0; i < 16; i++) put(8'(i * 11 + 1));
    chk(fifo_full && !fifo_empty, "R7 full at 16", {fifo_full, fifo_empty}, 2'b10);
    put(8'hEE);
    chk(fifo_full, "R8 still full", fifo_full, 1);
    cmd(9'h010);
    for (int i = 0; i < 16; i++) run_frame(8'h20, 8'(i * 11 + 1), "R7 R8 order", 1'b0, 8'h20);
    tick();
    chk(txd == 1'b1 && fifo_empty, "R8 dropped write not sent", {txd, fifo_empty}, 2'b11);

    cmd(9'h030);
    put(8'h55);
    tick(); tick(); tick();
    chk(txd == 1'b1 && !fifo_empty, "R9 disable wins", {txd, fifo_empty}, 2'b10);
    cmd(9'h010);
    run_frame(8'h20, 8'h55, "R9 enable resumes", 1'b0, 8'h20);
    tick();

    cmd(9'h080);
    chk(txd == 1'b0, "R6 break on", txd, 0);
    tick(); tick();
    chk(txd == 1'b0, "R6 break held", txd, 0);
    cmd(9'h100);
    chk(txd == 1'b1, "R6 break off", txd, 1);
    cmd(9'h180);
    chk(txd == 1'b1, "R6 release wins", txd, 1);

    put(8'h81);
    put(8'h82);
    tick(); tick();
    cmd(9'h002);
    chk(txd == 1'b1 && fifo_empty, "R5 abort frame", {txd, fifo_empty}, 2'b11);
    tick();
    chk(txd == 1'b1, "R5 stays idle", txd, 1);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h77; cmd_valid = 1'b1; cmd_word = 9'h002; end
    @(negedge clk) begin wr_en = 1'b0; cmd_valid = 1'b0; cmd_word = '0; end
    chk(fifo_empty, "R5 same-cycle write dropped", fifo_empty, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule